// File: doc/BRIEF.md
# Asynchronous SRAM access sequencer

This block lets clocked logic use an external asynchronous static RAM of 128K bytes. The RAM has 17 address lines, separate data-in and data-out paths with a drive enable for the shared pad, two chip enables of opposite polarity, a write strobe and an output strobe. The host issues one byte read or write at a time through a valid/ready request port. The block then steps the RAM pins through a fixed series of phases. Each phase lasts a parameter-set number of clocks, so that address setup, write pulse width, data setup, hold and read access time are all met at the chosen clock rate.

A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so the host applies back-pressure by holding its request until the handshake occurs. The response has no back-pressure: `rsp_valid` is a one-cycle pulse, and the host must take it in that cycle. The address lines change only while both chip enables are inactive. A write is one window in which both enables and the write strobe are active together. The pad driver is on only inside that window. After a read, a turnaround gap comes before any later write can drive the bus.

Top module: `sram_seq_ctrl`

## Requirements
- R1: An asynchronous active-low reset, applied at any time, including in the middle of an access, sets req_ready=1, rsp_valid=0, mem_cs_n=1, mem_cs2=0, mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 1 only when the sequencer is idle and goes to 0 in the cycle after an accept. The request inputs have no effect while req_valid is 0 or after the accept edge.
- R3: mem_addr loads req_addr at the accept edge. It holds that value for the whole access and changes only on an edge where mem_cs_n was 1 before and is 1 after.
- R4: A write shows the address for SETUP_CYC cycles with all strobes inactive. Then mem_cs_n=0, mem_cs2=1 and mem_we_n=0 together for exactly PULSE_CYC cycles. Then all strobes are inactive for HOLD_CYC cycles.
- R5: mem_dq_oe is 1 only while mem_we_n=0 and mem_oe_n=1. While it is 1, mem_dq_out equals the accepted write byte.
- R6: A read shows the address for SETUP_CYC cycles with all strobes inactive. Then both enables and mem_oe_n=0 are active for ACCESS_CYC+1 cycles. mem_dq_in is sampled at the end of the last of those cycles.
- R7: rsp_valid is a one-cycle pulse. For a read it rises SETUP_CYC+ACCESS_CYC+1 edges after the accept edge, with rsp_rdata holding the sampled byte. For a write it rises SETUP_CYC+PULSE_CYC+HOLD_CYC edges after the accept edge.
- R8: When mem_oe_n returns to 1 after a read, req_ready stays 0 for TURN_CYC cycles. A following write turns on mem_dq_oe exactly TURN_CYC+1+SETUP_CYC edges after that rise.
- R9: mem_we_n and mem_oe_n are never 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read, valid with rsp_valid after a read |
| mem_addr | output | 17 | RAM address lines |
| mem_cs_n | output | 1 | RAM enable, active low |
| mem_cs2 | output | 1 | RAM enable, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output strobe, active low |
| mem_dq_out | output | 8 | Data toward the RAM pad |
| mem_dq_in | input | 8 | Data from the RAM pad |
| mem_dq_oe | output | 1 | Pad driver enable |

## Verification
Every result falls at a fixed edge count after the accept edge. With the default parameters, a read completes after SETUP_CYC+ACCESS_CYC+1 = 6 edges and a write after SETUP_CYC+PULSE_CYC+HOLD_CYC = 5 edges. The write strobe stays low for PULSE_CYC = 3 cycles. After a read, the next write's driver turns on TURN_CYC+1+SETUP_CYC = 3 edges after the output strobe rises. The bench drives inputs and samples outputs on falling edges. It counts edges from the accept, and it compares the edge where the pulse appears against these sums rather than waiting loosely for it. A pin monitor samples 1 ns after each rising edge, which is where the pulse width, the addresses shown on the pins and the driven data are measured.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_TURN
  } seq_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that measures how long each phase lasts.
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_io_regs.sv
// Registers for the address and write byte taken at accept, and for the read byte.
module sram_io_regs #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept) begin
      addr_o  <= req_addr;
      wdata_o <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (capture) rdata_o <= dq_in;
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 3,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 4,
  parameter int TURN_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int MAX_LEN = max2(max2(SETUP_CYC, PULSE_CYC),
                                max2(max2(HOLD_CYC, ACCESS_CYC), TURN_CYC));
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] len_m1;
  logic             phase_last;
  logic             accept;
  logic             capture;
  logic             load;
  logic             rd_phase;
  logic             wr_phase;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_RD_CAPTURE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
      ST_RD_SETUP:   if (phase_last) state_d = ST_RD_WAIT;
      ST_RD_WAIT:    if (phase_last) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: state_d = ST_TURN;
      ST_TURN:       if (phase_last) state_d = ST_IDLE;
      ST_WR_SETUP:   if (phase_last) state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (phase_last) state_d = ST_WR_HOLD;
      ST_WR_HOLD:    if (phase_last) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // Length of the phase being entered, minus one.
  always_comb begin
    unique case (state_d)
      ST_RD_SETUP, ST_WR_SETUP: len_m1 = CNT_W'(SETUP_CYC - 1);
      ST_RD_WAIT:               len_m1 = CNT_W'(ACCESS_CYC - 1);
      ST_WR_PULSE:              len_m1 = CNT_W'(PULSE_CYC - 1);
      ST_WR_HOLD:               len_m1 = CNT_W'(HOLD_CYC - 1);
      ST_TURN:                  len_m1 = CNT_W'(TURN_CYC - 1);
      default:                  len_m1 = '0;
    endcase
  end

  assign load = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= capture || ((state_q == ST_WR_HOLD) && phase_last);
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (len_m1),
    .last     (phase_last)
  );

  sram_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .dq_in     (mem_dq_in),
    .addr_o    (mem_addr),
    .wdata_o   (mem_dq_out),
    .rdata_o   (rsp_rdata)
  );

  // Pin decode from the registered state
  assign rd_phase  = (state_q == ST_RD_WAIT) || (state_q == ST_RD_CAPTURE);
  assign wr_phase  = (state_q == ST_WR_PULSE);
  assign mem_cs_n  = !(rd_phase || wr_phase);
  assign mem_cs2   = rd_phase || wr_phase;
  assign mem_oe_n  = !rd_phase;
  assign mem_we_n  = !wr_phase;
  assign mem_dq_oe = wr_phase;

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W    = 17,
  parameter int PULSE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 16'd1;
    else                we_low_cnt <= '0;
  end

  // R9
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  // R5
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  // R3
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_cs_n && $past(mem_cs_n)));

  // R4
  strobe_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!mem_cs_n && mem_cs2));

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == 16'(PULSE_CYC)));

  // R6
  read_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (!mem_cs_n && mem_cs2 && mem_we_n));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  turn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !req_ready);

endmodule

bind sram_seq_ctrl sram_seq_chk #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_cs2   (mem_cs2),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;

  localparam int S = 1, P = 3, H = 1, A = 4, T = 1;
  localparam int NVEC = 11;
  // {write, addr[16:0], data[7:0]}
  localparam logic [25:0] VEC [0:NVEC-1] = '{
    {1'b1, 17'h00012, 8'h5A},
    {1'b1, 17'h1FF34, 8'hC3},
    {1'b0, 17'h00012, 8'h00},
    {1'b1, 17'h0AA77, 8'h81},
    {1'b0, 17'h1FF34, 8'h00},
    {1'b0, 17'h0AA77, 8'h00},
    {1'b1, 17'h00012, 8'hE7},
    {1'b0, 17'h00012, 8'h00},
    {1'b0, 17'h10055, 8'h00},
    {1'b1, 17'h1FFFF, 8'hFF},
    {1'b0, 17'h1FFFF, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_cs_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks = 0, fails = 0, tcount = 0;
  logic [7:0]  model_mem [0:255];
  logic [7:0]  exp_mem   [0:255];
  int          we_run = 0, last_pulse = 0, oe_rise_t = 0, dqoe_rise_t = 0, viol = 0;
  logic [16:0] pulse_addr = '0, rd_addr = '0;
  logic [7:0]  pulse_data = '0;
  logic        prev_we = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0;

  always #2.5 clk = ~clk;

  sram_seq_ctrl #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .ACCESS_CYC(A), .TURN_CYC(T))
  u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // RAM model: writes during the strobe overlap, drives only when a read is enabled.
  always @(posedge clk)
    if (!mem_cs_n && mem_cs2 && !mem_we_n) model_mem[mem_addr[7:0]] <= mem_dq_out;
  assign mem_dq_in = (!mem_cs_n && mem_cs2 && mem_we_n && !mem_oe_n) ?
                     model_mem[mem_addr[7:0]] : 8'hA5;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Pin monitor, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    tcount++;
    if (!mem_we_n) begin
      we_run++;
      pulse_addr = mem_addr;
      pulse_data = mem_dq_out;
    end
    if (mem_we_n && !prev_we) begin
      last_pulse = we_run;
      we_run = 0;
    end
    if (!mem_oe_n && prev_oe) rd_addr = mem_addr;
    if (mem_oe_n && !prev_oe) oe_rise_t = tcount;
    if (mem_dq_oe && !prev_dqoe) dqoe_rise_t = tcount;
    if (!mem_we_n && !mem_oe_n) viol++;
    if (mem_dq_oe && !(!mem_we_n && mem_oe_n)) viol++;
    if (mem_dq_oe && mem_dq_out != pulse_data) viol++;
    prev_we = mem_we_n; prev_oe = mem_oe_n; prev_dqoe = mem_dq_oe;
    if (tcount > 20000) begin
      chk(1'b0, "R7", "watchdog expired", tcount, 20000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_txn(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int lat;
    int exp_lat;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    chk(req_ready == 1'b1, "R2", "ready while idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0; req_addr = 17'h1ABCD; req_wdata = 8'h3C; req_write = ~wr;
    chk(req_ready == 1'b0, "R2", "ready after accept", int'(req_ready), 0);
    lat = 0;
    while (!rsp_valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    exp_lat = wr ? (S + P + H) : (S + A + 1);
    chk(lat == exp_lat, "R7", "done latency", lat, exp_lat);
    if (wr) begin
      exp_mem[a[7:0]] = d;
      chk(last_pulse == P, "R4", "write strobe width", last_pulse, P);
      chk(pulse_addr == a, "R3", "write address", int'(pulse_addr), int'(a));
      chk(pulse_data == d, "R5", "driven write byte", int'(pulse_data), int'(d));
    end else begin
      chk(rsp_rdata == exp_mem[a[7:0]], "R6", "read byte", int'(rsp_rdata),
          int'(exp_mem[a[7:0]]));
      chk(rd_addr == a, "R3", "read address", int'(rd_addr), int'(a));
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7", "done one cycle", int'(rsp_valid), 0);
    lat = 0;
    while (!req_ready && lat < 64) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      model_mem[i] = 8'h00;
      exp_mem[i]   = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "host side in reset",
        int'({req_ready, rsp_valid}), 2);
    chk(mem_cs_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "pins in reset",
        int'({mem_cs_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe}), 5'b10110);
    rst_n = 1'b1;

    // R2: request fields without valid are ignored
    req_addr = 17'h00033; req_write = 1'b1; req_wdata = 8'h99;
    repeat (4) @(negedge clk);
    chk(mem_cs_n && mem_we_n && req_ready, "R2", "no access without valid",
        int'({mem_cs_n, mem_we_n, req_ready}), 7);

    for (int v = 0; v < NVEC; v++)
      run_txn(VEC[v][25], VEC[v][24:8], VEC[v][7:0]);

    // R8: read followed at once by a write with valid held high
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h0AA77;
    @(negedge clk);
    req_write = 1'b1; req_addr = 17'h00077; req_wdata = 8'h42;
    for (int k = 0; k < 64 && !rsp_valid; k++) @(negedge clk);
    chk(rsp_rdata == 8'h81, "R6", "read before turnaround", int'(rsp_rdata), 8'h81);
    for (int k = 0; k < 64 && !req_ready; k++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 64 && !mem_dq_oe; k++) @(negedge clk);
    chk(dqoe_rise_t - oe_rise_t == T + 1 + S, "R8", "oe rise to drive gap",
        dqoe_rise_t - oe_rise_t, T + 1 + S);
    for (int k = 0; k < 64 && !rsp_valid; k++) @(negedge clk);
    exp_mem[8'h77] = 8'h42;
    repeat (2) @(negedge clk);

    // R1: reset in the middle of a write pulse
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00012; req_wdata = 8'h11;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem_we_n == 1'b0, "R4", "strobe low mid pulse", int'(mem_we_n), 0);
    rst_n = 1'b0;
    #1;
    chk(mem_we_n && mem_cs_n && !mem_cs2 && !mem_dq_oe && req_ready && !rsp_valid, "R1",
        "abort on reset", int'({mem_we_n, mem_cs_n, mem_cs2, mem_dq_oe, req_ready}), 5'b11001);
    @(negedge clk);
    rst_n = 1'b1;
    run_txn(1'b0, 17'h1FF34, 8'h00);
    run_txn(1'b0, 17'h00077, 8'h00);

    chk(viol == 0, "R9", "strobe overlap or drive outside window", viol, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule